// File: doc/BRIEF.md
# Integer ALU with Stored Condition Flags

This block is the integer execute stage of a small processor datapath. In one cycle it combines two operands under a 4-bit operation code. It supports four per-bit logic functions (AND, OR, exclusive-OR and mask-clear) and five adder-based functions (add, add with carry, subtract, subtract with carry and compare). The result and its write enable are combinational. The four condition flags (negative, zero, carry, overflow) are held in a register that loads on the clock edge when the flag-update enable is high.

The carry input of the chained operations is taken from the stored carry flag. Arithmetic wider than one word is therefore done one word per cycle, least significant word first, with the flag-update enable held high. After a subtraction the carry flag means "no borrow", which is the form the subtract-with-carry operation consumes. Compare computes the same difference as subtract and sets all four flags, but it does not request a result write.

The block has a single-cycle combinational datapath with no queueing, so it has no valid/ready handshake. The operation code, operands and enables are plain control inputs that are sampled every cycle.

Top module: `alu_flag_core`

## Requirements
- R1: Code 0 gives A AND B, code 1 gives A OR B and code 2 gives A XOR B, each computed independently on every bit position.
- R2: Code 3 (mask clear) gives A AND (NOT B). A bit set in B forces that result bit to 0, and a clear bit in B passes A through.
- R3: Code 4 (add) gives A+B modulo 2^WIDTH. When flags are updated, carry is set exactly when the unsigned sum does not fit in WIDTH bits.
- R4: Code 6 (subtract) gives A-B modulo 2^WIDTH. When flags are updated, carry is 1 if A >= B unsigned and 0 if a borrow occurred.
- R5: Code 5 gives A+B+C and code 7 gives A+(NOT B)+C, where C is the stored carry flag. This supports multi-word chaining.
- R6: For codes 0 to 8 with flag update, N becomes the result MSB and Z is set exactly when the result is all zeros.
- R7: For codes 4 to 8 with flag update, V is set exactly when the signed two's-complement result of the operation falls outside the WIDTH-bit signed range.
- R8: Code 8 (compare) drives the subtract difference and sets all four flags as subtract does. It holds res_wr low. Every other code holds res_wr high.
- R9: Logic codes 0 to 3 leave the stored C and V unchanged, even when flag update is enabled.
- R10: Codes 9 to 15 output A unchanged and leave all four flags unchanged.
- R11: The flags change only on a rising clock edge at which flag_we is high.
- R12: A synchronous reset clears the flags to 0. The flags bus packs {N,Z,C,V} in bits 3 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_sel | input | 4 | Operation code |
| opd_a | input | WIDTH | First operand |
| opd_b | input | WIDTH | Second operand or mask |
| flag_we | input | 1 | Load the flag register at the next edge |
| res_data | output | WIDTH | Combinational result |
| res_wr | output | 1 | Result should be written back |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The following properties are checked on every cycle:
- N and Z follow the previous result.
- The flags hold when the update enable is low.
- C and V survive logic operations.
- Compare never requests a write.
- Unused codes pass A through without touching the flags.
- The subtract carry matches the unsigned comparison.
- Reset clears the flags.

Arithmetic correctness of each result needs the bench's scenarios: the two chained operations consuming both values of the stored carry, and signed overflow across the whole operand space. These are covered by a full sweep over a 4-bit configuration, with expected values computed from integer arithmetic.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_CLR = 4'd3,
    OP_ADD = 4'd4,
    OP_ADC = 4'd5,
    OP_SUB = 4'd6,
    OP_SBC = 4'd7,
    OP_CMP = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       fn_sel,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] out_y
);
  // one two-input gate per bit pair, selected by the low two code bits
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (fn_sel)
        2'd0:    out_y[i] = in_a[i] & in_b[i];
        2'd1:    out_y[i] = in_a[i] | in_b[i];
        2'd2:    out_y[i] = in_a[i] ^ in_b[i];
        default: out_y[i] = in_a[i] & ~in_b[i];
      endcase
    end
  end
endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit #(
  parameter int WIDTH = 32
) (
  input  logic             do_sub,
  input  logic             use_carry,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf_out
);
  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [EXT-1:0]   wide;

  assign b_eff = do_sub ? ~in_b : in_b;
  // plain subtract injects 1; chained forms inject the stored carry
  assign cin   = use_carry ? carry_in : do_sub;
  assign wide  = {1'b0, in_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
  assign sum       = wide[WIDTH-1:0];
  assign carry_out = wide[WIDTH];
  assign ovf_out   = (in_a[WIDTH-1] == b_eff[WIDTH-1]) &&
                     (wide[WIDTH-1] != in_a[WIDTH-1]);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_nz,
  input  logic       upd_cv,
  input  alu_flags_t nxt,
  output alu_flags_t cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else begin
      if (upd_nz) begin
        cur.n <= nxt.n;
        cur.z <= nxt.z;
      end
      if (upd_cv) begin
        cur.c <= nxt.c;
        cur.v <= nxt.v;
      end
    end
  end
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  input  logic             flag_we,
  output logic [WIDTH-1:0] res_data,
  output logic             res_wr,
  output logic [3:0]       flags
);
  alu_op_e          op;
  logic             is_logic, is_arith, do_sub, use_carry;
  logic [WIDTH-1:0] lu_y, add_y;
  logic             add_c, add_v;
  alu_flags_t       cur, nxt;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    is_logic  = 1'b0;
    is_arith  = 1'b0;
    do_sub    = 1'b0;
    use_carry = 1'b0;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_CLR: is_logic = 1'b1;
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; use_carry = 1'b1; end
      OP_SUB, OP_CMP: begin is_arith = 1'b1; do_sub = 1'b1; end
      OP_SBC: begin is_arith = 1'b1; do_sub = 1'b1; use_carry = 1'b1; end
      default: ;
    endcase
  end

  alu_logic_unit #(.WIDTH(WIDTH)) logic_i (
    .fn_sel (op_sel[1:0]),
    .in_a   (opd_a),
    .in_b   (opd_b),
    .out_y  (lu_y)
  );

  alu_add_unit #(.WIDTH(WIDTH)) add_i (
    .do_sub    (do_sub),
    .use_carry (use_carry),
    .carry_in  (cur.c),
    .in_a      (opd_a),
    .in_b      (opd_b),
    .sum       (add_y),
    .carry_out (add_c),
    .ovf_out   (add_v)
  );

  always_comb begin
    if (is_logic)      res_data = lu_y;
    else if (is_arith) res_data = add_y;
    else               res_data = opd_a;
  end

  assign res_wr = (op != OP_CMP);

  assign nxt.n = res_data[WIDTH-1];
  assign nxt.z = (res_data == '0);
  assign nxt.c = add_c;
  assign nxt.v = add_v;

  alu_flag_reg flag_i (
    .clk    (clk),
    .rst    (rst),
    .upd_nz (flag_we & (is_logic | is_arith)),
    .upd_cv (flag_we & is_arith),
    .nxt    (nxt),
    .cur    (cur)
  );

  assign flags = cur;
endmodule

// File: rtl/alu_flag_core_chk.sv
module alu_flag_core_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opd_a,
  input logic [WIDTH-1:0] opd_b,
  input logic             flag_we,
  input logic [WIDTH-1:0] res_data,
  input logic             res_wr,
  input logic [3:0]       flags
);
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> flags == 4'b0000);

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags));

  assert_nz_track_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel <= 4'd8) |=>
      (flags[3] == $past(res_data[WIDTH-1])) &&
      (flags[2] == ($past(res_data) == '0)));

  assert_cv_kept_logic_R9: assert property (@(posedge clk) disable iff (rst)
    (op_sel < 4'd4) |=> flags[1:0] == $past(flags[1:0]));

  assert_sub_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel == 4'd6) |=> flags[1] == ($past(opd_a) >= $past(opd_b)));

  assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    res_wr == (op_sel != 4'd8));

  assert_unused_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 4'd8) |-> res_data == opd_a);

  assert_unused_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 4'd8) |=> $stable(flags));
endmodule

bind alu_flag_core alu_flag_core_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_sel   (op_sel),
  .opd_a    (opd_a),
  .opd_b    (opd_b),
  .flag_we  (flag_we),
  .res_data (res_data),
  .res_wr   (res_wr),
  .flags    (flags)
);

// File: tb/alu_flag_core_tb_top.sv
module alu_flag_core_tb_top;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;
  localparam int H = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_sel = 4'd0;
  logic [W-1:0] opd_a = '0;
  logic [W-1:0] opd_b = '0;
  logic         flag_we = 1'b0;
  logic [W-1:0] res_data;
  logic         res_wr;
  logic [3:0]   flags;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  alu_flag_core #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opd_a(opd_a), .opd_b(opd_b),
    .flag_we(flag_we), .res_data(res_data), .res_wr(res_wr), .flags(flags)
  );

  function automatic string req_of(int op);
    case (op)
      0, 1, 2: return "R1";
      3:       return "R2";
      4:       return "R3";
      5, 7:    return "R5";
      6:       return "R4";
      8:       return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation: drive at negedge, check result, check flags after edge
  task automatic apply(input int op, input int a, input int b, input bit we,
                       input int exp_res, input bit exp_wr, input int exp_fl,
                       input bit do_chk);
    @(negedge clk);
    op_sel = op[3:0]; opd_a = a[W-1:0]; opd_b = b[W-1:0]; flag_we = we;
    #1;
    if (do_chk) begin
      check(int'(res_data) == exp_res && res_wr == exp_wr, req_of(op), "result/wr",
            {res_wr, res_data}, {exp_wr, exp_res[W-1:0]});
    end
    @(negedge clk);
    if (do_chk)
      check(int'(flags) == exp_fl, (op < 4) ? "R9" : (op > 8 ? "R10" : "R7"),
            "flags", flags, exp_fl);
    flag_we = 1'b0;
  endtask

  // set stored flags to {0,1,c,0} with an add of known outcome
  task automatic preset(input bit c);
    if (c) apply(4, M, 1, 1'b1, 0, 1'b1, 4'b0110, 1'b0);
    else   apply(4, 0, 0, 1'b1, 0, 1'b1, 4'b0100, 1'b0);
  endtask

  function automatic int sgn(int x);
    return (x >= H) ? x - (M + 1) : x;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(flags == 4'b0000, "R12", "flags after reset", flags, 0);
    rst = 1'b0;

    for (int c = 0; c < 2; c++) begin
      for (int op = 0; op < 16; op++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            int s, r, sv, cf, vf, fl, nf, zf;
            bit wr;
            cf = c; vf = 0; sv = 0; s = 0;
            case (op)
              0: s = a & b;
              1: s = a | b;
              2: s = a ^ b;
              3: s = a & ~b & M;
              4: begin s = a + b;     sv = sgn(a) + sgn(b); end
              5: begin s = a + b + c; sv = sgn(a) + sgn(b) + c; end
              6, 8: begin s = a + (~b & M) + 1; sv = sgn(a) - sgn(b); end
              7: begin s = a + (~b & M) + c; sv = sgn(a) - sgn(b) - (1 - c); end
              default: s = a;
            endcase
            r  = s & M;
            wr = (op != 8);
            nf = (r >> (W - 1)) & 1;
            zf = (r == 0);
            if (op >= 4 && op <= 8) begin
              cf = (s >> W) & 1;
              vf = (sv < -H || sv > H - 1) ? 1 : 0;
            end
            if (op > 8) fl = {28'd0, 1'b0, 1'b1, c[0], 1'b0};
            else        fl = (nf << 3) | (zf << 2) | (cf << 1) | vf;
            preset(c[0]);
            apply(op, a, b, 1'b1, r, wr, fl, 1'b1);
          end
        end
      end
    end

    // R11: update enable low keeps flags across a borrowing subtract
    preset(1'b1);
    apply(6, 0, 1, 1'b0, M, 1'b1, 4'b0110, 1'b1);
    // R4 boundary: equal operands, no borrow, carry set, zero set
    preset(1'b0);
    apply(6, 5, 5, 1'b1, 0, 1'b1, 4'b0110, 1'b1);
    // R5 chained 8-bit add 0x9F + 0x71 = 0x110, low word then high word
    preset(1'b0);
    apply(4, 15, 1, 1'b1, 0, 1'b1, 4'b0110, 1'b1);
    apply(5, 9, 7, 1'b1, 1, 1'b1, 4'b0010, 1'b1);

    // R12: reset clears non-zero flags
    preset(1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(flags == 4'b0000, "R12", "flags after mid-run reset", flags, 0);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule